// File: doc/BRIEF.md
# Orthogonal-Code XOR Spreader and Despreader Link

This block connects N senders to one serial chip line and recovers one chosen sender's bit on the far side. Each symbol period, every sender contributes one bit. Each bit is multiplied by that sender's unit-vector code, so sender i's code has its only 1 at chip position i. The N spread words are folded together by XOR into a single N-chip word. That word is shifted out at one chip per clock, least-significant position first. A strobe marks the first chip of every symbol.

On the receive side, each chip is ANDed with the matching chip of the selected destination's code. The AND results are OR-accumulated over the N chips, which yields the selected sender's original bit. The destination index is captured on the first chip of each symbol. Recovered bits enter a small in-order result queue that drives a valid/ready output port.

Back-pressure rules:
- The parallel input is accepted only while `in_ready` is high.
- `in_ready` is low during the first N-1 chips of a symbol in flight.
- `in_ready` is also low whenever the results already queued plus the symbol in flight would fill the result queue. Because of this, a stalled consumer eventually halts the transmitter, and no result is ever dropped.
- On the output side, `out_bit` is held while `out_valid` is high and `out_ready` is low.

Top module: `ortho_xor_link`

## Requirements
- R1: After an active-low synchronous reset, `chip_vld` and `out_valid` are 0 and `in_ready` is 1. No chip strobe appears before the first accepted input word.
- R2: A word accepted on a clock edge (`in_valid` and `in_ready` both high) begins transmission in the following cycle. Chip k of the symbol is sender bit k, which is the XOR of the unit-vector spread words. Chip 0 (bit 0) is sent first, one chip per clock.
- R3: Each symbol is exactly N consecutive cycles with `chip_vld` high. `chip_sos` is 1 on the first of those cycles only.
- R4: `in_ready` is 0 during the first N-1 chips of a symbol. In the last chip cycle it may be 1, so a word accepted there starts its first chip in the very next cycle, with no gap.
- R5: The recovered bit equals bit `dest_sel` of the transmitted word, where `dest_sel` is the value present on the first chip. When the queue is empty, `out_valid` rises in the cycle after the last chip.
- R6: A change of `dest_sel` after the first chip of a symbol does not affect that symbol's result. It applies from the next symbol on.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_bit` does not change on the next cycle.
- R8: Results leave in symbol order, with none lost or repeated. When the consumer stalls, `in_ready` falls once the queued results plus the symbol in flight reach the queue depth (RES_DEPTH, default 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be accepted |
| in_data | input | N | One bit per sender, bit i from sender i |
| chip_out | output | 1 | Current chip of the mixed sequence |
| chip_sos | output | 1 | First chip of a symbol |
| chip_vld | output | 1 | A chip is present on `chip_out` |
| dest_sel | input | clog2(N) | Sender index to recover, captured on the first chip |
| out_valid | output | 1 | Recovered bit available |
| out_ready | input | 1 | Consumer takes the recovered bit |
| out_bit | output | 1 | Recovered sender bit |

## Verification
Properties cover the following on every cycle:
- the strobe falls on symbol boundaries only, and the chip run is unbroken;
- `in_ready` is low mid-symbol;
- the first chip follows an accepted word;
- results appear only right after a last chip;
- results hold under stall.

Other behaviour needs the bench scenarios, because it depends on data and history. These are the correctness of every chip and every recovered bit, the effect of changing the destination mid-symbol, ordering through a stalled queue, and the absence of any loss. The bench therefore sweeps every input word against every destination, spins the destination on each clock, and runs long consumer stalls.

// File: rtl/ortho_pkg.sv
package ortho_pkg;

  // Unit-vector code: sender s owns chip position s.
  function automatic logic code_chip(input int unsigned sender, input int unsigned pos);
    return sender == pos;
  endfunction

endpackage

// File: rtl/ortho_spread_tx.sv
module ortho_spread_tx
  import ortho_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_data,
  input  logic         room,
  output logic         busy,
  output logic         chip_out,
  output logic         chip_sos,
  output logic         chip_vld
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] spread [N];
  logic [N-1:0] mixed;
  logic [N-1:0] shreg;
  logic [CW-1:0] pos;
  logic          active;
  logic          last;
  logic          accept;

  // Spread each sender's bit with its own code.
  for (genvar s = 0; s < N; s++) begin : g_snd
    for (genvar k = 0; k < N; k++) begin : g_chip
      assign spread[s][k] = in_data[s] & code_chip(s, k);
    end
  end

  // Combine the spread words by XOR.
  always_comb begin
    mixed = '0;
    for (int s = 0; s < N; s++) mixed ^= spread[s];
  end

  assign last     = active && (pos == CW'(N-1));
  assign in_ready = (!active || last) && room;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
      shreg  <= '0;
    end else if (accept) begin
      active <= 1'b1;
      pos    <= '0;
      shreg  <= mixed;
    end else if (active) begin
      shreg <= shreg >> 1;
      pos   <= pos + 1'b1;
      if (last) active <= 1'b0;
    end
  end

  assign busy     = active;
  assign chip_vld = active;
  assign chip_out = active & shreg[0];
  assign chip_sos = active && (pos == '0);

endmodule

// File: rtl/ortho_despread_rx.sv
module ortho_despread_rx
  import ortho_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chip_vld,
  input  logic          chip_sos,
  input  logic          chip_in,
  input  logic [IW-1:0] dest_sel,
  output logic          res_push,
  output logic          res_bit
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic [CW-1:0] pos;
  logic [CW-1:0] idx;
  logic [IW-1:0] dest_q;
  logic [IW-1:0] dest_use;
  logic          acc;
  logic          hit;
  logic          acc_next;

  assign idx      = chip_sos ? '0 : pos;
  assign dest_use = chip_sos ? dest_sel : dest_q;
  assign hit      = chip_in & code_chip(32'(dest_use), 32'(idx));
  assign acc_next = (chip_sos ? 1'b0 : acc) | hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      dest_q <= '0;
      acc    <= 1'b0;
    end else if (chip_vld) begin
      acc <= acc_next;
      pos <= (idx == CW'(N-1)) ? '0 : idx + 1'b1;
      if (chip_sos) dest_q <= dest_sel;
    end
  end

  assign res_push = chip_vld && (idx == CW'(N-1));
  assign res_bit  = acc_next;

endmodule

// File: rtl/ortho_result_fifo.sv
module ortho_result_fifo #(
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic                       wdata,
  input  logic                       rd,
  output logic                       rvalid,
  output logic                       rdata,
  output logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH+1);

  logic [DEPTH-1:0] mem;
  logic [PW-1:0]    wptr;
  logic [PW-1:0]    rptr;
  logic             do_rd;

  assign rvalid = (occ != '0);
  assign do_rd  = rd && rvalid;
  assign rdata  = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem  <= '0;
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (wr) begin
        mem[wptr] <= wdata;
        wptr      <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      end
      if (do_rd) rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      if (wr && !do_rd)      occ <= occ + OW'(1);
      else if (!wr && do_rd) occ <= occ - OW'(1);
    end
  end

endmodule

// File: rtl/ortho_xor_link.sv
module ortho_xor_link #(
  parameter int N         = 8,
  parameter int RES_DEPTH = 2,
  localparam int IW       = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N-1:0]  in_data,
  output logic          chip_out,
  output logic          chip_sos,
  output logic          chip_vld,
  input  logic [IW-1:0] dest_sel,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_bit
);
  localparam int OW = $clog2(RES_DEPTH+1);

  logic          room;
  logic          tx_busy;
  logic          res_push;
  logic          res_bit;
  logic [OW-1:0] occ;

  // Credit: queued results plus the symbol in flight must fit.
  assign room = (32'(occ) + 32'(tx_busy)) < 32'(RES_DEPTH);

  ortho_spread_tx #(.N(N)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .room     (room),
    .busy     (tx_busy),
    .chip_out (chip_out),
    .chip_sos (chip_sos),
    .chip_vld (chip_vld)
  );

  ortho_despread_rx #(.N(N), .IW(IW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_vld (chip_vld),
    .chip_sos (chip_sos),
    .chip_in  (chip_out),
    .dest_sel (dest_sel),
    .res_push (res_push),
    .res_bit  (res_bit)
  );

  ortho_result_fifo #(.DEPTH(RES_DEPTH)) u_q (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (res_push),
    .wdata  (res_bit),
    .rd     (out_ready),
    .rvalid (out_valid),
    .rdata  (out_bit),
    .occ    (occ)
  );

endmodule

// File: rtl/ortho_xor_link_sva.sv
module ortho_xor_link_sva #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [N-1:0]  in_data,
  input logic          chip_out,
  input logic          chip_sos,
  input logic          chip_vld,
  input logic [IW-1:0] dest_sel,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_bit
);
  int unsigned seen;
  int unsigned curpos;
  logic        ever_acc;

  assign curpos = chip_sos ? 0 : seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen     <= 0;
      ever_acc <= 1'b0;
    end else begin
      if (chip_vld) seen <= curpos + 1;
      if (in_valid && in_ready) ever_acc <= 1'b1;
    end
  end

  assert_no_chip_before_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chip_vld |-> ever_acc);

  assert_first_chip_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (chip_vld && chip_sos && (chip_out == $past(in_data[0]))));

  assert_sos_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chip_vld |-> (chip_sos == (seen == 0 || seen == N)));

  assert_symbol_unbroken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_vld && curpos < N-1) |=> chip_vld);

  assert_ready_low_midsym_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_vld && curpos < N-1) |-> !in_ready);

  assert_result_after_last_chip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(chip_vld && curpos == N-1));

  assert_hold_when_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

endmodule

bind ortho_xor_link ortho_xor_link_sva #(.N(N), .IW(IW)) u_sva (.*);

// File: tb/sim_ortho_xor_link.sv
`timescale 1ns/1ps
module sim_ortho_xor_link;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [N-1:0]  in_data = '0;
  logic          chip_out, chip_sos, chip_vld;
  logic [IW-1:0] dest_sel = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          out_bit;

  always #2 clk = ~clk;

  ortho_xor_link #(.N(N), .RES_DEPTH(2)) u0 (.*);

  int errors = 0, checks = 0, cyc = 0, phase = 0;
  int or_mode = 0;
  int dest_fix = 0;
  bit dest_spin = 1'b0;
  int sent = 0, got = 0;
  int idx = N-1;
  logic [N-1:0] cur = '0;
  logic [N-1:0] exp_words[$];
  logic         exp_bits[$];
  logic prev_ov = 1'b0, prev_or = 1'b0, prev_bit = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Input side drivers: out_ready and dest_sel, changed just after each rising edge.
  initial forever begin
    @(posedge clk);
    #1;
    cyc++;
    case (or_mode)
      0: out_ready = 1'b1;
      1: out_ready = ((cyc % 3) != 0);
      default: out_ready = 1'b0;
    endcase
    dest_sel = dest_spin ? IW'(cyc) : IW'(dest_fix);
  end

  // Monitor, sampling at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (chip_vld) begin
        if (idx == N-1) begin
          chk(chip_sos == 1'b1, "R3", "strobe at symbol start", int'(chip_sos), 1);
          if (exp_words.size() > 0) begin
            cur = exp_words.pop_front();
          end else begin
            chk(1'b0, "R2", "chip without accepted word", 1, 0);
          end
          idx = 0;
          exp_bits.push_back(cur[dest_sel]);
        end else begin
          chk(chip_sos == 1'b0, "R3", "strobe inside symbol", int'(chip_sos), 0);
          idx++;
        end
        chk(chip_out == cur[idx], "R2", "chip value", int'(chip_out), int'(cur[idx]));
        if (idx < N-1) begin
          chk(in_ready == 1'b0, "R4", "ready mid-symbol", int'(in_ready), 0);
        end else if (phase == 1 && in_valid) begin
          chk(in_ready == 1'b1, "R4", "ready on last chip", int'(in_ready), 1);
        end
      end else if (idx < N-1) begin
        chk(1'b0, "R3", "gap inside symbol", 0, 1);
        idx = N-1;
      end

      if (prev_ov && !prev_or) begin
        chk(out_valid == 1'b1, "R7", "valid held", int'(out_valid), 1);
        chk(out_bit == prev_bit, "R7", "bit held", int'(out_bit), int'(prev_bit));
      end
      if (out_valid && out_ready) begin
        if (exp_bits.size() > 0) begin
          logic e;
          e = exp_bits.pop_front();
          chk(out_bit == e, (phase == 2) ? "R6" : "R5", "recovered bit", int'(out_bit), int'(e));
        end else begin
          chk(1'b0, "R8", "extra result", 1, 0);
        end
        got++;
      end

      if (in_valid && in_ready) begin
        exp_words.push_back(in_data);
        sent++;
      end
      prev_ov  = out_valid;
      prev_or  = out_ready;
      prev_bit = out_bit;
    end
  end

  task automatic send(input logic [N-1:0] w);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    chk(chip_vld == 1'b0, "R1", "no chip after reset", int'(chip_vld), 0);
    chk(out_valid == 1'b0, "R1", "no result after reset", int'(out_valid), 0);
    idle(6);
    @(negedge clk);
    chk(chip_vld == 1'b0, "R1", "no chip while idle", int'(chip_vld), 0);
    @(posedge clk);
    #1;

    // Phase 1: every word against every destination, consumer always ready.
    phase = 1;
    for (int d = 0; d < N; d++) begin
      dest_fix = d;
      for (int w = 0; w < (1 << N); w++) send(N'(w));
    end
    idle(3*N);

    // Phase 2: destination changes every clock, consumer with gaps.
    phase = 2;
    or_mode = 1;
    dest_spin = 1'b1;
    for (int w = 0; w < (1 << N); w++) send(N'(w * 37 + 11));
    idle(4*N);
    dest_spin = 1'b0;

    // Phase 3: consumer stalls, transmitter must stop.
    phase = 3;
    or_mode = 2;
    dest_fix = 5;
    fork
      begin
        send(8'hA5);
        send(8'h20);
        send(8'hFF);
        send(8'h00);
      end
      begin
        idle(10*N);
        @(negedge clk);
        chk(in_ready == 1'b0, "R8", "ready low while queue full", int'(in_ready), 0);
        chk(out_valid == 1'b1, "R8", "result waiting", int'(out_valid), 1);
        @(posedge clk);
        #1;
        or_mode = 0;
      end
    join
    idle(4*N);
    @(negedge clk);
    chk(got == sent, "R8", "results equal words", got, sent);
    chk(exp_bits.size() == 0, "R8", "no pending expected bits", exp_bits.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule